// File: doc/BRIEF.md
# Transmit Frame Launcher

This block sends one Ethernet frame that software has already built in a transmit buffer. The buffer holds the complete wire image: an 8-byte header of preamble and start delimiter, the frame body, and a 4-byte FCS. Software starts a send by writing the total byte count to the launcher. The launcher checks that the count is inside the legal range and that the header bytes are correct. If both checks pass, it reads the body through a synchronous buffer read port and presents it one byte at a time on a ready/valid byte stream. The header and the FCS are not sent.

A completion interrupt pulses once for every processed count write, whether the frame was sent or refused. After a successful send the count reads back as zero. After a refusal the count keeps the value that was written, so software can tell the two outcomes apart. CRC generation and the physical layer belong to other blocks.

Top module: `tx_frame_launcher`

## Requirements
- R1: While the launcher is idle, a write with a nonzero count starts processing, and the written value is visible on `txCount` from the next cycle on.
- R2: A write of zero has no effect: the count, the interrupt and the stream all stay unchanged.
- R3: A count below 64 is refused, and no byte is sent.
- R4: A count above 1530 is refused, and no byte is sent.
- R5: Buffer bytes 0 to 6 must each be 0x55 and byte 7 must be 0xD5; any other header refuses the frame, and no byte is sent.
- R6: An accepted frame of count N sends exactly N-12 bytes, taken in address order from buffer offsets 8 to N-5. The buffer returns the byte at `bufRdAddr` on `bufRdData` one cycle after `bufRdEn` is high.
- R7: `txLast` is high on the final sent byte of a frame and on no other byte.
- R8: A byte that is offered and not taken stays on the stream with the same data and last flag until `txReady` is high.
- R9: The count becomes zero only when the final byte is taken; a refused frame leaves the count at the written value.
- R10: `txIrq` is high for exactly one cycle for every processed frame, whether it was sent or refused.
- R11: Count writes that arrive while a frame is being checked or sent are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cntWrEn | input | 1 | Count register write strobe |
| cntWrData | input | CNT_W | Byte count to write |
| txCount | output | CNT_W | Current value of the count register |
| bufRdEn | output | 1 | Buffer read request |
| bufRdAddr | output | ADDR_W | Buffer byte address |
| bufRdData | input | 8 | Buffer data, one cycle after the request |
| txData | output | 8 | Stream byte |
| txValid | output | 1 | Stream byte is valid |
| txReady | input | 1 | Downstream accepts the byte |
| txLast | output | 1 | Final byte of the frame |
| txIrq | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a count write that arrives in the middle of a stream that is being stalled by backpressure. The bench releases such a write only after part of the expected byte queue has drained, while `txReady` follows a pseudo-random pattern. A wrongly accepted write would then show up as an extra interrupt, a changed count or stray bytes. Header refusals are reached by flipping one header byte at each end and in the middle, and the length limits are probed one byte inside and one byte outside each bound.

// File: rtl/txl_pkg.sv
package txl_pkg;

  localparam int HDR_BYTES = 8;
  localparam int TRL_BYTES = 4;
  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN,
    ST_PRE,
    ST_PCHK,
    ST_LOAD,
    ST_SEND,
    ST_FIN,
    ST_REJ
  } txl_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;   // capture written count, reset address and header check
    logic clrCnt;    // clear count after successful send
    logic rdIssue;   // issue buffer read at current address, then advance
    logic preRead;   // the issued read belongs to the header check
    logic capture;   // load returned buffer byte into the output register
  } txl_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lenOk;     // count inside legal range
    logic preDone;   // all header reads issued
    logic preBad;    // a header byte mismatched
    logic lastByte;  // output register holds the final body byte
  } txl_status_t;

endpackage

// File: rtl/txl_ctrl.sv
module txl_ctrl
  import txl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  logic        txReady,
  input  txl_status_t stat,
  output txl_strobe_t strb,
  output logic        txValid,
  output logic        txIrq
);

  txl_state_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.loadCnt = 1'b1;
          stateNxt     = ST_LEN;
        end
      end
      ST_LEN: begin
        if (!stat.lenOk) begin
          stateNxt = ST_REJ;
        end else begin
          strb.rdIssue = 1'b1;
          strb.preRead = 1'b1;
          stateNxt     = ST_PRE;
        end
      end
      ST_PRE: begin
        if (!stat.preDone) begin
          strb.rdIssue = 1'b1;
          strb.preRead = 1'b1;
        end else begin
          stateNxt = ST_PCHK;
        end
      end
      ST_PCHK: begin
        if (stat.preBad) begin
          stateNxt = ST_REJ;
        end else begin
          strb.rdIssue = 1'b1;
          stateNxt     = ST_LOAD;
        end
      end
      ST_LOAD: begin
        strb.capture = 1'b1;
        stateNxt     = ST_SEND;
      end
      ST_SEND: begin
        if (txReady) begin
          if (stat.lastByte) begin
            strb.clrCnt = 1'b1;
            stateNxt    = ST_FIN;
          end else begin
            strb.rdIssue = 1'b1;
            stateNxt     = ST_LOAD;
          end
        end
      end
      ST_FIN:  stateNxt = ST_IDLE;
      ST_REJ:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign txValid = (state == ST_SEND);
  assign txIrq   = (state == ST_FIN) || (state == ST_REJ);

  // R10: completion pulse never lasts two cycles
  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    txIrq |=> !txIrq);

  // R5: no byte is offered after a header mismatch was seen
  assert_no_send_bad_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && stat.preBad) |-> 1'b0);

endmodule

// File: rtl/txl_dpath.sv
module txl_dpath
  import txl_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 11,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1530
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cntWrData,
  input  txl_strobe_t       strb,
  input  logic [7:0]        bufRdData,
  output txl_status_t       stat,
  output logic [CNT_W-1:0]  txCount,
  output logic              bufRdEn,
  output logic [ADDR_W-1:0] bufRdAddr,
  output logic [7:0]        txData
);

  localparam logic [CNT_W-1:0]  MinCnt  = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0]  MaxCnt  = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0]  TrlCnt  = CNT_W'(TRL_BYTES);
  localparam logic [ADDR_W-1:0] HdrAddr = ADDR_W'(HDR_BYTES);
  localparam logic [2:0]        SfdIdx  = 3'(HDR_BYTES - 1);

  logic [CNT_W-1:0]  cntReg;
  logic [ADDR_W-1:0] rdAddr;
  logic              chkPend;
  logic [2:0]        chkIdx;
  logic              preBad;
  logic [7:0]        dataReg;
  logic [7:0]        expHdr;

  // count register
  always_ff @(posedge clk) begin
    if (!rst_n)            cntReg <= '0;
    else if (strb.loadCnt) cntReg <= cntWrData;
    else if (strb.clrCnt)  cntReg <= '0;
  end

  // buffer address counter
  always_ff @(posedge clk) begin
    if (!rst_n)            rdAddr <= '0;
    else if (strb.loadCnt) rdAddr <= '0;
    else if (strb.rdIssue) rdAddr <= rdAddr + 1'b1;
  end

  // header check pipeline, compares the byte returned one cycle after issue
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chkPend <= 1'b0;
      chkIdx  <= '0;
    end else begin
      chkPend <= strb.rdIssue && strb.preRead;
      chkIdx  <= rdAddr[2:0];
    end
  end

  assign expHdr = (chkIdx == SfdIdx) ? SFD_BYTE : PRE_BYTE;

  always_ff @(posedge clk) begin
    if (!rst_n)                                preBad <= 1'b0;
    else if (strb.loadCnt)                     preBad <= 1'b0;
    else if (chkPend && (bufRdData != expHdr)) preBad <= 1'b1;
  end

  // output byte register
  always_ff @(posedge clk) begin
    if (!rst_n)            dataReg <= '0;
    else if (strb.capture) dataReg <= bufRdData;
  end

  assign stat.lenOk    = (cntReg >= MinCnt) && (cntReg <= MaxCnt);
  assign stat.preDone  = (rdAddr == HdrAddr);
  assign stat.preBad   = preBad;
  assign stat.lastByte = (CNT_W'(rdAddr) == (cntReg - TrlCnt));

  assign txCount   = cntReg;
  assign bufRdEn   = strb.rdIssue;
  assign bufRdAddr = rdAddr;
  assign txData    = dataReg;

  // R6: body reads stay between the header and the trailer
  assert_body_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdIssue && !strb.preRead) |->
      ((CNT_W'(rdAddr) >= CNT_W'(HDR_BYTES)) && (CNT_W'(rdAddr) < cntReg - TrlCnt)));

  // R5: header reads only cover the first eight bytes
  assert_header_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdIssue && strb.preRead) |-> (rdAddr < HdrAddr));

endmodule

// File: rtl/tx_frame_launcher.sv
module tx_frame_launcher
  import txl_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 11,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1530
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  output logic [CNT_W-1:0]  txCount,
  output logic              bufRdEn,
  output logic [ADDR_W-1:0] bufRdAddr,
  input  logic [7:0]        bufRdData,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              txLast,
  output logic              txIrq
);

  txl_strobe_t strb;
  txl_status_t stat;
  logic        startReq;

  assign startReq = cntWrEn && (cntWrData != '0);

  txl_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startReq (startReq),
    .txReady  (txReady),
    .stat     (stat),
    .strb     (strb),
    .txValid  (txValid),
    .txIrq    (txIrq)
  );

  txl_dpath #(
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .cntWrData (cntWrData),
    .strb      (strb),
    .bufRdData (bufRdData),
    .stat      (stat),
    .txCount   (txCount),
    .bufRdEn   (bufRdEn),
    .bufRdAddr (bufRdAddr),
    .txData    (txData)
  );

  assign txLast = txValid && stat.lastByte;

  // R8: offered byte is held until taken
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));

  // R9: count only reaches zero through the final handshake
  assert_clear_only_on_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((txCount != '0) && !(txValid && txReady && txLast)) |=> (txCount != '0));

  // R11: writes during a send leave the count alone
  assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && cntWrEn && !(txReady && txLast)) |=> $stable(txCount));

  // R3 / R4: bytes are only offered for an in-range count
  assert_send_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txValid |-> ((txCount >= CNT_W'(MIN_LEN)) && (txCount <= CNT_W'(MAX_LEN))));

endmodule

// File: tb/tb_tx_frame_launcher.sv
`timescale 1ns/1ps
module tb_tx_frame_launcher;

  localparam int CNT_W  = 16;
  localparam int ADDR_W = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cntWrEn = 1'b0;
  logic [CNT_W-1:0]  cntWrData = '0;
  logic [CNT_W-1:0]  txCount;
  logic              bufRdEn;
  logic [ADDR_W-1:0] bufRdAddr;
  logic [7:0]        bufRdData;
  logic [7:0]        txData;
  logic              txValid;
  logic              txReady = 1'b0;
  logic              txLast;
  logic              txIrq;

  always #4 clk = ~clk;

  tx_frame_launcher #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .txCount(txCount), .bufRdEn(bufRdEn), .bufRdAddr(bufRdAddr),
    .bufRdData(bufRdData), .txData(txData), .txValid(txValid),
    .txReady(txReady), .txLast(txLast), .txIrq(txIrq)
  );

  // buffer model: one-cycle read latency
  logic [7:0] mem [0:(1<<ADDR_W)-1];
  always_ff @(posedge clk) if (bufRdEn) bufRdData <= mem[bufRdAddr];

  int nCmp = 0;
  int nBad = 0;
  int irqSeen = 0;
  int cycles = 0;
  int readyMode = 0;
  logic [7:0] expQ[$];
  logic [15:0] lfsr = 16'hACE1;
  logic prevStall = 1'b0;
  logic prevIrq = 1'b0;
  logic [7:0] stallData = '0;
  logic stallLast = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // reference model: every clock, compare stream and interrupt against expectations
  always @(negedge clk) begin
    if (rst_n) begin
      if (prevStall)
        chk(txValid && txData == stallData && txLast == stallLast, "R8 held byte",
            int'(txData), int'(stallData));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      txReady = (readyMode == 0) ? 1'b1 : (lfsr[0] | lfsr[5]);
      if (txValid && txReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R6 unexpected byte", int'(txData), -1);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          chk(txData == e, "R6 byte value", int'(txData), int'(e));
          chk(txLast == (expQ.size() == 0), "R7 last flag", int'(txLast),
              int'(expQ.size() == 0));
        end
      end
      prevStall = txValid && !txReady;
      stallData = txData;
      stallLast = txLast;
      if (txIrq) begin
        irqSeen++;
        if (prevIrq) chk(1'b0, "R10 pulse width", 2, 1);
      end
      prevIrq = txIrq;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      chk(1'b0, "watchdog expired", cycles, 190000);
      finishRun();
    end
  end

  task automatic writeCount(input int value);
    @(negedge clk);
    cntWrEn = 1'b1;
    cntWrData = CNT_W'(value);
    @(negedge clk);
    cntWrEn = 1'b0;
    cntWrData = '0;
  endtask

  task automatic runFrame(input int cnt, input int badIdx, input bit expOk,
                          input bit midWrite, input string req);
    int irq0;
    for (int i = 0; i < 8; i++) mem[i] = (i == 7) ? 8'hD5 : 8'h55;
    for (int i = 8; i < cnt && i < (1<<ADDR_W); i++) mem[i] = 8'((i * 13 + cnt) & 255);
    if (badIdx >= 0) mem[badIdx] = mem[badIdx] ^ 8'h01;
    if (expOk) for (int i = 8; i <= cnt - 5; i++) expQ.push_back(mem[i]);
    irq0 = irqSeen;
    writeCount(cnt);
    chk(txCount == CNT_W'(cnt), {"R1 count visible ", req}, int'(txCount), cnt);
    if (midWrite) begin
      for (int t = 0; t < 5000 && expQ.size() > cnt - 12 - 5; t++) @(negedge clk);
      writeCount(200);
      writeCount(64);
    end
    for (int t = 0; t < 20000 && irqSeen == irq0; t++) @(negedge clk);
    repeat (midWrite ? 700 : 5) @(negedge clk);
    chk(irqSeen == irq0 + 1, {"R10 one pulse ", req}, irqSeen - irq0, 1);
    chk(txCount == (expOk ? '0 : CNT_W'(cnt)), {"R9 count after ", req},
        int'(txCount), expOk ? 0 : cnt);
    chk(expQ.size() == 0, {"R6 all bytes sent ", req}, expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txCount == '0, "reset count", int'(txCount), 0);
    chk(!txValid && !txIrq && !bufRdEn, "reset outputs",
        int'({txValid, txIrq, bufRdEn}), 0);

    readyMode = 0;
    runFrame(64, -1, 1'b1, 1'b0, "R6 min frame");
    runFrame(63, -1, 1'b0, 1'b0, "R3 short");
    begin
      int irq0;
      irq0 = irqSeen;
      writeCount(0);
      repeat (20) @(negedge clk);
      chk(txCount == CNT_W'(63), "R2 zero write keeps count", int'(txCount), 63);
      chk(irqSeen == irq0, "R2 zero write no pulse", irqSeen - irq0, 0);
    end
    runFrame(1531, -1, 1'b0, 1'b0, "R4 long");
    readyMode = 1;
    runFrame(1530, -1, 1'b1, 1'b0, "R4 max frame");
    runFrame(80, 0, 1'b0, 1'b0, "R5 byte0");
    runFrame(80, 7, 1'b0, 1'b0, "R5 byte7");
    runFrame(80, 3, 1'b0, 1'b0, "R5 byte3");
    runFrame(100, -1, 1'b1, 1'b1, "R11 busy write");
    runFrame(65, -1, 1'b1, 1'b0, "R8 stalled");
    readyMode = 0;
    runFrame(97, 8, 1'b1, 1'b0, "R5 body ignored");
    finishRun();
  end

endmodule